// File: doc/BRIEF.md
# Shared-Pin Event Interrupt Controller

This block collects event flags from a radio baseband into three groups (wake, transmit and receive) and drives one shared interrupt line to a host. Every source has its own status bit and its own enable bit. A status bit records its event whether or not it is enabled, so a host can either poll the status registers or wait on the pin. Reading a status register returns its contents and clears it. Once the enable bits have been applied, the transmit/receive mode bit decides which of the transmit or receive groups may reach the pin. The wake group reaches the pin in either mode.

The host reaches the block through a small register bus: an address, write data, a write strobe, a read strobe and registered read data. The receive group has two lanes of four flags each. In two of the four data-rate codes the upper lane is unused, and its events are dropped. A configuration bit sets the pin polarity. The pin output and its output-enable together model an open-drain line (when active low) or an open-source line (when active high).

Top module: `intc_shared_pin`

## Requirements
- R1: After reset, every register reads 0x00, `irq_oe` is 0 and `irq_pin` is 0.
- R2: Addresses 0x07 (receive enable, 8 bits), 0x0D (transmit enable, bits [3:0]), 0x1C (wake enable, bit 0) and 0x05 (configuration, bit 0) are written with `bus_wr` and read back. Unused bits read 0, and so does any unmapped address. `bus_rdata` is updated on the clock edge that samples `bus_rd` and holds its value when no read is made.
- R3: Transmit events (`tx_evt[3:0]`) set bits [3:0] of 0x0E. Receive events set 0x08, with lane A in bits [3:0] and lane B in bits [7:4]. Both happen whatever the enable bits hold.
- R4: Reading 0x08 or 0x0E returns the current status and clears it. An event that arrives on the same cycle as the clearing read stays set. Writes to status addresses have no effect.
- R5: A rising edge of `osc_ready` sets bit 0 of 0x1D. Reading 0x1D returns that bit and clears it.
- R6: `irq_oe` becomes 1 one clock edge after some status bit is set while its enable bit is set and its group is allowed, and it is 0 otherwise.
- R7: With `tx_mode`=1 the receive group cannot drive the pin. With `tx_mode`=0 the transmit group cannot drive it. Changing `tx_mode` does not change any enable register.
- R8: With `rate_mode` 2'b01 (64 chips/bit) or 2'b10 (32 chips/bit double-rate), lane B receive events are dropped and never set status. Codes 2'b00 and 2'b11 let them through.
- R9: `irq_pin` equals configuration bit 0. A value of 1 means active high, driven only high. A value of 0 means active low, driven only low.
- R10: The wake group drives the pin in both transmit and receive mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears status registers) |
| bus_rdata | output | 8 | Registered read data |
| tx_evt | input | 4 | Transmit event pulses |
| rx_evt | input | 8 | Receive event pulses, lane A [3:0], lane B [7:4] |
| tx_mode | input | 1 | 1 = transmit mode, 0 = receive mode |
| rate_mode | input | 2 | Data-rate code |
| osc_ready | input | 1 | Oscillator running indication |
| irq_pin | output | 1 | Level driven onto the interrupt line |
| irq_oe | output | 1 | Drive enable of the interrupt line |

## Verification
An event, a read or a write is sampled on a clock edge. A status change from it is visible through a read strobe placed on any later cycle. The read data from that strobe appears right after the edge that samples it. `irq_oe` follows one edge after the status, enable and mode values that cause it, and `irq_pin` follows the configuration register as soon as it is written. The bench drives inputs on the falling edge and keeps a model that advances on each rising edge. At the following falling edge it compares the pin, the drive enable and the read data (for the cycle just after a read) against that model. This keeps every comparison aligned with these latencies.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Register addresses decoded by the host driver
  localparam int A_CFG   = 'h05;
  localparam int A_RX_EN = 'h07;
  localparam int A_RX_ST = 'h08;
  localparam int A_TX_EN = 'h0D;
  localparam int A_TX_ST = 'h0E;
  localparam int A_WK_EN = 'h1C;
  localparam int A_WK_ST = 'h1D;

  typedef enum logic [1:0] {
    RATE_NORM  = 2'b00,
    RATE_64    = 2'b01,
    RATE_32DDR = 2'b10,
    RATE_32    = 2'b11
  } rate_e;
endpackage

// File: rtl/intc_status_bank.sv
module intc_status_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr,
  output logic [W-1:0] stat
);
  logic [W-1:0] stat_d;

  // Set has priority over a clearing read, bit by bit
  for (genvar i = 0; i < W; i++) begin : gen_bit
    always_comb begin
      if (evt[i])   stat_d[i] = 1'b1;
      else if (clr) stat_d[i] = 1'b0;
      else          stat_d[i] = stat[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= stat_d;
  end

  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((stat & $past(evt)) == $past(evt))); // R4
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && evt == '0) |=> (stat == '0)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && evt == '0) |=> $stable(stat)); // R3
endmodule

// File: rtl/intc_wake_detect.sv
module intc_wake_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_ready,
  input  logic clr,
  output logic pend
);
  logic osc_q;
  logic rise;
  logic pend_d;

  assign rise = osc_ready & ~osc_q;

  always_comb begin
    if (rise)     pend_d = 1'b1;
    else if (clr) pend_d = 1'b0;
    else          pend_d = pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      osc_q <= osc_ready;
      pend  <= pend_d;
    end
  end

  AST_WAKE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_ready) |=> pend); // R5
  AST_WAKE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !osc_ready) |=> !pend); // R5
endmodule

// File: rtl/intc_regfile.sv
module intc_regfile #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int TX_N   = 4,
  parameter int RX_N   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [RX_N-1:0]   rx_stat,
  input  logic [TX_N-1:0]   tx_stat,
  input  logic              wk_pend,
  output logic [RX_N-1:0]   rx_en,
  output logic [TX_N-1:0]   tx_en,
  output logic              wk_en,
  output logic              pol,
  output logic              clr_rx,
  output logic              clr_tx,
  output logic              clr_wk,
  output logic [DATA_W-1:0] bus_rdata
);
  import irq_pkg::*;

  logic sel_cfg, sel_rx_en, sel_rx_st, sel_tx_en, sel_tx_st, sel_wk_en, sel_wk_st;
  logic [RX_N-1:0]   rx_en_d;
  logic [TX_N-1:0]   tx_en_d;
  logic              wk_en_d, pol_d;
  logic [DATA_W-1:0] rd_mux, rdata_d;

  assign sel_cfg   = (bus_addr == ADDR_W'(A_CFG));
  assign sel_rx_en = (bus_addr == ADDR_W'(A_RX_EN));
  assign sel_rx_st = (bus_addr == ADDR_W'(A_RX_ST));
  assign sel_tx_en = (bus_addr == ADDR_W'(A_TX_EN));
  assign sel_tx_st = (bus_addr == ADDR_W'(A_TX_ST));
  assign sel_wk_en = (bus_addr == ADDR_W'(A_WK_EN));
  assign sel_wk_st = (bus_addr == ADDR_W'(A_WK_ST));

  assign clr_rx = bus_rd & sel_rx_st;
  assign clr_tx = bus_rd & sel_tx_st;
  assign clr_wk = bus_rd & sel_wk_st;

  always_comb begin
    rx_en_d = rx_en;
    tx_en_d = tx_en;
    wk_en_d = wk_en;
    pol_d   = pol;
    if (bus_wr) begin
      if (sel_rx_en) rx_en_d = bus_wdata[RX_N-1:0];
      if (sel_tx_en) tx_en_d = bus_wdata[TX_N-1:0];
      if (sel_wk_en) wk_en_d = bus_wdata[0];
      if (sel_cfg)   pol_d   = bus_wdata[0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_rx_en)      rd_mux = DATA_W'(rx_en);
    else if (sel_rx_st) rd_mux = DATA_W'(rx_stat);
    else if (sel_tx_en) rd_mux = DATA_W'(tx_en);
    else if (sel_tx_st) rd_mux = DATA_W'(tx_stat);
    else if (sel_wk_en) rd_mux = DATA_W'(wk_en);
    else if (sel_wk_st) rd_mux = DATA_W'(wk_pend);
    else if (sel_cfg)   rd_mux = DATA_W'(pol);
    rdata_d = bus_rd ? rd_mux : bus_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en     <= '0;
      tx_en     <= '0;
      wk_en     <= 1'b0;
      pol       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      rx_en     <= rx_en_d;
      tx_en     <= tx_en_d;
      wk_en     <= wk_en_d;
      pol       <= pol_d;
      bus_rdata <= rdata_d;
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R2
  AST_EN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(rx_en) && $stable(tx_en) && $stable(wk_en)); // R7
endmodule

// File: rtl/intc_pin_drive.sv
module intc_pin_drive #(
  parameter int TX_N = 4,
  parameter int RX_N = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_mode,
  input  logic            pol,
  input  logic [TX_N-1:0] tx_stat,
  input  logic [TX_N-1:0] tx_en,
  input  logic [RX_N-1:0] rx_stat,
  input  logic [RX_N-1:0] rx_en,
  input  logic            wk_pend,
  input  logic            wk_en,
  output logic            irq_pin,
  output logic            irq_oe
);
  logic tx_hit, rx_hit, wk_hit;
  logic irq_d, irq_q;

  assign tx_hit = |(tx_stat & tx_en);
  assign rx_hit = |(rx_stat & rx_en);
  assign wk_hit = wk_pend & wk_en;

  always_comb begin
    irq_d = wk_hit;
    if (tx_mode) irq_d = irq_d | tx_hit;
    else         irq_d = irq_d | rx_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  // Driven level is fixed by polarity; only the enable toggles
  assign irq_oe  = irq_q;
  assign irq_pin = pol;

  AST_WAKE_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
    wk_hit |=> irq_oe); // R10
  AST_RX_BLOCKED_IN_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && !wk_hit && !tx_hit) |=> !irq_oe); // R7
  AST_TX_BLOCKED_IN_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_mode && !wk_hit && !rx_hit) |=> !irq_oe); // R7
endmodule

// File: rtl/intc_shared_pin.sv
module intc_shared_pin #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int TX_N   = 4,
  parameter int LANE_N = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_wr,
  input  logic                bus_rd,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [TX_N-1:0]     tx_evt,
  input  logic [2*LANE_N-1:0] rx_evt,
  input  logic                tx_mode,
  input  logic [1:0]          rate_mode,
  input  logic                osc_ready,
  output logic                irq_pin,
  output logic                irq_oe
);
  import irq_pkg::*;

  localparam int RX_N  = 2 * LANE_N;
  localparam int LANES = 2;

  logic [1:0]      rst_sync;
  logic            rst_s_n;
  logic            b_block;
  logic [RX_N-1:0] rx_evt_ok;
  logic [RX_N-1:0] rx_stat, rx_en;
  logic [TX_N-1:0] tx_stat, tx_en;
  logic            wk_pend, wk_en, pol;
  logic            clr_rx, clr_tx, clr_wk;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  assign b_block = (rate_mode == RATE_64) || (rate_mode == RATE_32DDR);

  for (genvar g = 0; g < LANES; g++) begin : gen_lane
    if (g == 0) begin : g_a
      assign rx_evt_ok[g*LANE_N +: LANE_N] = rx_evt[g*LANE_N +: LANE_N];
    end else begin : g_b
      assign rx_evt_ok[g*LANE_N +: LANE_N] =
        b_block ? '0 : rx_evt[g*LANE_N +: LANE_N];
    end
  end

  intc_status_bank #(.W(RX_N)) u_rx_bank (
    .clk(clk), .rst_n(rst_s_n), .evt(rx_evt_ok), .clr(clr_rx), .stat(rx_stat));

  intc_status_bank #(.W(TX_N)) u_tx_bank (
    .clk(clk), .rst_n(rst_s_n), .evt(tx_evt), .clr(clr_tx), .stat(tx_stat));

  intc_wake_detect u_wake (
    .clk(clk), .rst_n(rst_s_n), .osc_ready(osc_ready), .clr(clr_wk), .pend(wk_pend));

  intc_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TX_N(TX_N), .RX_N(RX_N)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .rx_stat(rx_stat), .tx_stat(tx_stat),
    .wk_pend(wk_pend), .rx_en(rx_en), .tx_en(tx_en), .wk_en(wk_en), .pol(pol),
    .clr_rx(clr_rx), .clr_tx(clr_tx), .clr_wk(clr_wk), .bus_rdata(bus_rdata));

  intc_pin_drive #(.TX_N(TX_N), .RX_N(RX_N)) u_pin (
    .clk(clk), .rst_n(rst_s_n), .tx_mode(tx_mode), .pol(pol),
    .tx_stat(tx_stat), .tx_en(tx_en), .rx_stat(rx_stat), .rx_en(rx_en),
    .wk_pend(wk_pend), .wk_en(wk_en), .irq_pin(irq_pin), .irq_oe(irq_oe));

  AST_LANE_B_SILENT: assert property (@(posedge clk) disable iff (!rst_s_n)
    (b_block && rx_stat[RX_N-1:LANE_N] == '0) |=> (rx_stat[RX_N-1:LANE_N] == '0)); // R8
endmodule

// File: tb/sim_intc_shared_pin.sv
`timescale 1ns/1ps
module sim_intc_shared_pin;
  import irq_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [3:0] tx_evt = '0;
  logic [7:0] rx_evt = '0;
  logic       tx_mode = 1'b0;
  logic [1:0] rate_mode = 2'b00;
  logic       osc_ready = 1'b0;
  logic       irq_pin, irq_oe;

  int n_chk = 0, n_fail = 0;

  intc_shared_pin u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .tx_evt(tx_evt),
    .rx_evt(rx_evt), .tx_mode(tx_mode), .rate_mode(rate_mode),
    .osc_ready(osc_ready), .irq_pin(irq_pin), .irq_oe(irq_oe));

  always #4 clk = ~clk;

  // Reference model built from the requirements
  logic [7:0] m_rx, m_rxen, m_rdata;
  logic [3:0] m_tx, m_txen;
  logic       m_wk, m_wken, m_cfg, m_osc, m_irq;

  function automatic logic [7:0] m_read(input logic [4:0] a);
    case (int'(a))
      A_RX_EN: return m_rxen;
      A_RX_ST: return m_rx;
      A_TX_EN: return {4'h0, m_txen};
      A_TX_ST: return {4'h0, m_tx};
      A_WK_EN: return {7'h0, m_wken};
      A_WK_ST: return {7'h0, m_wk};
      A_CFG:   return {7'h0, m_cfg};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic lane_b_off(input logic [1:0] r);
    return (r == 2'b01) || (r == 2'b10);
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    if (int'(a) == A_RX_ST || int'(a) == A_TX_ST) return "R3";
    if (int'(a) == A_WK_ST) return "R5";
    return "R2";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rx <= '0; m_rxen <= '0; m_rdata <= '0; m_tx <= '0; m_txen <= '0;
      m_wk <= 1'b0; m_wken <= 1'b0; m_cfg <= 1'b0; m_osc <= 1'b0; m_irq <= 1'b0;
    end else begin
      logic [7:0] rxe;
      rxe = lane_b_off(rate_mode) ? (rx_evt & 8'h0F) : rx_evt;
      if (bus_rd) m_rdata <= m_read(bus_addr);
      m_rx <= rxe | ((bus_rd && int'(bus_addr) == A_RX_ST) ? 8'h00 : m_rx);
      m_tx <= tx_evt | ((bus_rd && int'(bus_addr) == A_TX_ST) ? 4'h0 : m_tx);
      m_wk <= (osc_ready & ~m_osc) | ((bus_rd && int'(bus_addr) == A_WK_ST) ? 1'b0 : m_wk);
      m_osc <= osc_ready;
      if (bus_wr && int'(bus_addr) == A_RX_EN) m_rxen <= bus_wdata;
      if (bus_wr && int'(bus_addr) == A_TX_EN) m_txen <= bus_wdata[3:0];
      if (bus_wr && int'(bus_addr) == A_WK_EN) m_wken <= bus_wdata[0];
      if (bus_wr && int'(bus_addr) == A_CFG)   m_cfg  <= bus_wdata[0];
      m_irq <= (m_wk & m_wken) | (tx_mode ? |(m_tx & m_txen) : |(m_rx & m_rxen));
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: inputs already set; check at the following falling edge
  task automatic step();
    logic       was_rd;
    logic [4:0] ad;
    was_rd = bus_rd;
    ad = bus_addr;
    @(posedge clk);
    @(negedge clk);
    chk("R6", {7'h0, irq_oe}, {7'h0, m_irq});
    chk("R9", {7'h0, irq_pin}, {7'h0, m_cfg});
    if (was_rd) chk(tag_of(ad), bus_rdata, m_rdata);
    bus_wr = 1'b0; bus_rd = 1'b0; tx_evt = '0; rx_evt = '0;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    bus_addr = 5'(a); bus_wdata = d; bus_wr = 1'b1; step();
  endtask

  task automatic rd(input int a);
    bus_addr = 5'(a); bus_rd = 1'b1; step();
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int addrs[8];
    addrs = '{A_CFG, A_RX_EN, A_RX_ST, A_TX_EN, A_TX_ST, A_WK_EN, A_WK_ST, 'h00};
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1", {7'h0, irq_oe}, 8'h00);
    chk("R1", {7'h0, irq_pin}, 8'h00);
    for (int i = 0; i < 7; i++) begin
      rd(addrs[i]);
      chk("R1", bus_rdata, 8'h00);
    end

    // R2: write/readback, unused bits zero
    wr(A_RX_EN, 8'hA5); rd(A_RX_EN); chk("R2", bus_rdata, 8'hA5);
    wr(A_TX_EN, 8'hFF); rd(A_TX_EN); chk("R2", bus_rdata, 8'h0F);
    wr(A_TX_EN, 8'h00); wr(A_RX_EN, 8'h00);

    // R3: status records events with enables clear
    tx_evt = 4'b0101; step();
    rd(A_TX_ST); chk("R3", bus_rdata, 8'h05);
    chk("R3", {7'h0, irq_oe}, 8'h00);

    // R4: set wins over clearing read; writes to status ignored
    rx_evt = 8'h03; step();
    rx_evt = 8'h01; rd(A_RX_ST); chk("R4", bus_rdata, 8'h03);
    rd(A_RX_ST); chk("R4", bus_rdata, 8'h01);
    wr(A_RX_ST, 8'hFF); rd(A_RX_ST); chk("R4", bus_rdata, 8'h00);

    // R7: mode gating keeps enables
    wr(A_RX_EN, 8'hFF);
    rx_evt = 8'h10; step();
    tx_mode = 1'b1; step();
    chk("R7", {7'h0, irq_oe}, 8'h00);
    rd(A_RX_EN); chk("R7", bus_rdata, 8'hFF);
    tx_mode = 1'b0; step();
    chk("R7", {7'h0, irq_oe}, 8'h01);
    rd(A_RX_ST); chk("R7", bus_rdata, 8'h10);

    // R8: lane B dropped in two rate codes
    rate_mode = 2'b01; rx_evt = 8'hF0; step();
    rd(A_RX_ST); chk("R8", bus_rdata, 8'h00);
    rate_mode = 2'b10; rx_evt = 8'hF2; step();
    rd(A_RX_ST); chk("R8", bus_rdata, 8'h02);
    rate_mode = 2'b11; rx_evt = 8'hF0; step();
    rd(A_RX_ST); chk("R8", bus_rdata, 8'hF0);
    rate_mode = 2'b00; wr(A_RX_EN, 8'h00);

    // R5 / R10: wake on oscillator start, ungated by mode
    wr(A_WK_EN, 8'h01);
    tx_mode = 1'b1; osc_ready = 1'b1; step(); step();
    chk("R10", {7'h0, irq_oe}, 8'h01);
    tx_mode = 1'b0; step();
    chk("R10", {7'h0, irq_oe}, 8'h01);
    rd(A_WK_ST); chk("R5", bus_rdata, 8'h01);
    rd(A_WK_ST); chk("R5", bus_rdata, 8'h00);

    // R9: polarity
    wr(A_CFG, 8'h01); chk("R9", {7'h0, irq_pin}, 8'h01);
    wr(A_CFG, 8'h00); chk("R9", {7'h0, irq_pin}, 8'h00);

    // Constrained random traffic against the model
    for (int c = 0; c < 3000; c++) begin
      int r;
      r = int'($urandom % 16);
      if (r < 4) begin
        bus_addr = 5'(addrs[$urandom % 8]); bus_rd = 1'b1;
      end else if (r < 6) begin
        bus_addr = 5'(addrs[$urandom % 8]); bus_wdata = 8'($urandom); bus_wr = 1'b1;
      end
      if ($urandom % 6 == 0) tx_evt = 4'($urandom);
      if ($urandom % 6 == 0) rx_evt = 8'($urandom);
      if ($urandom % 50 == 0) tx_mode = ~tx_mode;
      if ($urandom % 40 == 0) rate_mode = 2'($urandom);
      if ($urandom % 30 == 0) osc_ready = ~osc_ready;
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule